// File: doc/BRIEF.md
# Phase Interpolator Control Encoder

This block turns a 9-bit phase control code into the digital controls of a delay-chain phase interpolator. The chain has 32 taps. Two multiplexers pick one odd-numbered tap and one even-numbered tap. A blender of 16 identical units, whose outputs are tied together, mixes the two picked edges. Each chain stage also has a mixer that either buffers its tap or blends the tap with the input clock edge.

The encoder also needs the clock period, measured in unit delays. A row of arbiters reports it as a thermometer. The encoder cleans isolated bubbles out of that thermometer, turns it into a stage count and reduces the coarse part of the code modulo that count. As a result, phase rotation wraps at the real period rather than at the end of the chain. Exactly one stage mixer, the one at the period boundary, is put in blend mode, which keeps rotation monotonic across the wrap.

All four outputs are registered. They change only on a cycle with the load strobe, so the analog mux network never sees intermediate select values. Code and period are plain control inputs sampled on the load strobe; there is no data stream and no back-pressure.

Top module: `pi_ctrl_encoder`

## Requirements
- R1: While `rst_n` is low and after its release, before any load, the outputs are `odd_sel`=0, `even_sel`=0, `blend_therm`=0 and `stage_mode`=32'h8000_0000. These are the values for code 0 with a 32-stage period.
- R2: Outputs take new values only at a rising clock edge where `load` is 1. At all other edges they hold, whatever `code` and `arb_therm` do.
- R3: Bit i of `arb_therm` at 1 means stage i fits in the period. Each bit is first replaced by the majority of itself and its two neighbours, with a virtual 1 below bit 0 and a virtual 0 above bit 31. The period count P is the index of the first 0 in the cleaned vector, or 32 when there is none. A count below 2 is raised to 2.
- R4: The active tap is T = `code[8:4]` mod P.
- R5: The partner tap is N = T+1, or 0 when T is 31. `odd_sel` is the odd one of {T, N} shifted right by one, and `even_sel` is the even one shifted right by one. The two selects therefore always name adjacent taps.
- R6: Let W = `code[3:0]`. `blend_therm` is a thermometer filled from bit 0, and a 1 routes that blender unit to the odd input. The number of ones is W when N is odd, and 16−W when N is even, so W units always follow the later tap.
- R7: `stage_mode` is one-hot, with its single 1 at bit P−1. That bit marks the boundary stage whose mixer blends with the input clock; every other stage buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Strobe: register new outputs this edge |
| code | input | 9 | Phase code: coarse tap in [8:4], blend weight in [3:0] |
| arb_therm | input | 32 | Arbiter thermometer of stages per period |
| odd_sel | output | 4 | Odd-tap mux select (tap = 2*sel+1) |
| even_sel | output | 4 | Even-tap mux select (tap = 2*sel) |
| blend_therm | output | 16 | Blender unit control, 1 = odd input |
| stage_mode | output | 32 | Per-stage mixer control, 1 = blend with clock |

## Verification
A wrong period count appears at the ports on the clock edge after the load that uses it. It shows up both as `stage_mode` pointing to the wrong boundary stage and as a tap index that fails to wrap. A parity slip in the tap mapping shows in the same cycle as selects that are not adjacent, or as a blender weight that follows the earlier tap instead of the later one. Missing load gating shows one edge after any input change without a strobe.

// File: rtl/pi_enc_pkg.sv
package pi_enc_pkg;
  localparam int unsigned NTAP_DEF  = 32;
  localparam int unsigned WBITS_DEF = 4;
  localparam int unsigned CODE_DEF  = 9;
  localparam int unsigned MIN_PER   = 2;
endpackage

// File: rtl/pi_therm_decode.sv
module pi_therm_decode #(
  parameter int unsigned NTAP  = 32,
  parameter int unsigned MINP  = 2,
  localparam int unsigned CNT_W = $clog2(NTAP) + 1
) (
  input  logic [NTAP-1:0]  therm,
  output logic [CNT_W-1:0] count
);
  logic [NTAP+1:0] ext;
  logic [NTAP-1:0] clean;

  assign ext = {1'b0, therm, 1'b1};

  genvar g;
  generate
    for (g = 0; g < NTAP; g++) begin : g_maj
      assign clean[g] = (ext[g] & ext[g+1]) | (ext[g+1] & ext[g+2]) | (ext[g] & ext[g+2]);
    end
  endgenerate

  logic [CNT_W-1:0] raw;
  always_comb begin
    raw = CNT_W'(NTAP);
    for (int i = NTAP - 1; i >= 0; i--) begin
      if (!clean[i]) raw = CNT_W'(i);
    end
  end

  assign count = (raw < CNT_W'(MINP)) ? CNT_W'(MINP) : raw;
endmodule

// File: rtl/pi_tap_map.sv
module pi_tap_map #(
  parameter int unsigned NTAP     = 32,
  parameter int unsigned COARSE_W = 5,
  localparam int unsigned CNT_W  = $clog2(NTAP) + 1,
  localparam int unsigned TAP_W  = $clog2(NTAP),
  localparam int unsigned SEL_W  = $clog2(NTAP / 2)
) (
  input  logic [COARSE_W-1:0] coarse,
  input  logic [CNT_W-1:0]    count,
  output logic [SEL_W-1:0]    odd_sel,
  output logic [SEL_W-1:0]    even_sel,
  output logic                later_odd
);
  logic [CNT_W-1:0] wide;
  logic [TAP_W-1:0] cur_tap;
  logic [TAP_W-1:0] nxt_tap;
  logic [TAP_W-1:0] odd_tap;
  logic [TAP_W-1:0] even_tap;

  assign wide    = CNT_W'(coarse) % count;
  assign cur_tap = wide[TAP_W-1:0];
  assign nxt_tap = (cur_tap == TAP_W'(NTAP - 1)) ? '0 : cur_tap + TAP_W'(1);

  always_comb begin
    if (cur_tap[0]) begin
      odd_tap  = cur_tap;
      even_tap = nxt_tap;
    end else begin
      odd_tap  = nxt_tap;
      even_tap = cur_tap;
    end
  end

  assign odd_sel   = odd_tap[TAP_W-1:1];
  assign even_sel  = even_tap[TAP_W-1:1];
  assign later_odd = nxt_tap[0];
endmodule

// File: rtl/pi_blend_weight.sv
module pi_blend_weight #(
  parameter int unsigned WBITS = 4,
  localparam int unsigned NUNIT = 1 << WBITS
) (
  input  logic [WBITS-1:0] weight,
  input  logic             later_odd,
  output logic [NUNIT-1:0] therm
);
  logic [WBITS:0] ones;
  assign ones = later_odd ? {1'b0, weight} : ((WBITS+1)'(NUNIT) - {1'b0, weight});

  genvar k;
  generate
    for (k = 0; k < NUNIT; k++) begin : g_unit
      assign therm[k] = ((WBITS+1)'(k) < ones);
    end
  endgenerate
endmodule

// File: rtl/pi_boundary_mark.sv
module pi_boundary_mark #(
  parameter int unsigned NTAP = 32,
  localparam int unsigned CNT_W = $clog2(NTAP) + 1
) (
  input  logic [CNT_W-1:0] count,
  output logic [NTAP-1:0]  mark
);
  genvar i;
  generate
    for (i = 0; i < NTAP; i++) begin : g_stage
      assign mark[i] = (count == CNT_W'(i + 1));
    end
  endgenerate
endmodule

// File: rtl/pi_ctrl_encoder.sv
module pi_ctrl_encoder
  import pi_enc_pkg::*;
#(
  parameter int unsigned NTAP   = NTAP_DEF,
  parameter int unsigned WBITS  = WBITS_DEF,
  parameter int unsigned CODE_W = CODE_DEF,
  localparam int unsigned NUNIT    = 1 << WBITS,
  localparam int unsigned SEL_W    = $clog2(NTAP / 2),
  localparam int unsigned CNT_W    = $clog2(NTAP) + 1,
  localparam int unsigned COARSE_W = CODE_W - WBITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic [NTAP-1:0]   arb_therm,
  output logic [SEL_W-1:0]  odd_sel,
  output logic [SEL_W-1:0]  even_sel,
  output logic [NUNIT-1:0]  blend_therm,
  output logic [NTAP-1:0]   stage_mode
);
  logic [CNT_W-1:0] per_cnt;
  logic [SEL_W-1:0] odd_nx, even_nx;
  logic             later_odd;
  logic [NUNIT-1:0] blend_nx;
  logic [NTAP-1:0]  mark_nx;

  pi_therm_decode #(.NTAP(NTAP), .MINP(MIN_PER)) dec_i (
    .therm(arb_therm), .count(per_cnt)
  );

  pi_tap_map #(.NTAP(NTAP), .COARSE_W(COARSE_W)) map_i (
    .coarse(code[CODE_W-1:WBITS]), .count(per_cnt),
    .odd_sel(odd_nx), .even_sel(even_nx), .later_odd(later_odd)
  );

  pi_blend_weight #(.WBITS(WBITS)) blend_i (
    .weight(code[WBITS-1:0]), .later_odd(later_odd), .therm(blend_nx)
  );

  pi_boundary_mark #(.NTAP(NTAP)) mark_i (
    .count(per_cnt), .mark(mark_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_sel     <= '0;
      even_sel    <= '0;
      blend_therm <= '0;
      stage_mode  <= {1'b1, {(NTAP-1){1'b0}}};
    end else if (load) begin
      odd_sel     <= odd_nx;
      even_sel    <= even_nx;
      blend_therm <= blend_nx;
      stage_mode  <= mark_nx;
    end
  end
endmodule

// File: rtl/pi_enc_chk.sv
module pi_enc_chk #(
  parameter int unsigned NTAP  = 32,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned NUNIT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [SEL_W-1:0] odd_sel,
  input logic [SEL_W-1:0] even_sel,
  input logic [NUNIT-1:0] blend_therm,
  input logic [NTAP-1:0]  stage_mode
);
  logic [NUNIT:0] blend_inc;
  assign blend_inc = {1'b0, blend_therm} + (NUNIT+1)'(1);

  // R2
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(odd_sel) && $stable(even_sel)));
  // R2
  hold_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(blend_therm) && $stable(stage_mode)));
  // R5
  adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_sel == even_sel) || (odd_sel + SEL_W'(1) == even_sel) ||
    (odd_sel == SEL_W'(NTAP/2 - 1) && even_sel == '0));
  // R6
  blend_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, blend_therm} & blend_inc) == '0));
  // R7
  boundary_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stage_mode) == 1);
  // R3
  min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_mode[0] == 1'b0);
endmodule

bind pi_ctrl_encoder pi_enc_chk #(.NTAP(NTAP), .SEL_W(SEL_W), .NUNIT(NUNIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .load(load), .odd_sel(odd_sel), .even_sel(even_sel),
  .blend_therm(blend_therm), .stage_mode(stage_mode)
);

// File: tb/pi_ctrl_encoder_tb_top.sv
module pi_ctrl_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [8:0]  code = '0;
  logic [31:0] arb_therm = '0;
  logic [3:0]  odd_sel, even_sel;
  logic [15:0] blend_therm;
  logic [31:0] stage_mode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pi_ctrl_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .code(code), .arb_therm(arb_therm),
    .odd_sel(odd_sel), .even_sel(even_sel), .blend_therm(blend_therm), .stage_mode(stage_mode)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ref_period(logic [31:0] t);
    logic [33:0] e;
    logic [31:0] c;
    int p;
    e = {1'b0, t, 1'b1};
    for (int i = 0; i < 32; i++) begin
      int s;
      s = int'(e[i]) + int'(e[i+1]) + int'(e[i+2]);
      c[i] = (s >= 2);
    end
    p = 32;
    for (int i = 31; i >= 0; i--) if (c[i] == 1'b0) p = i;
    if (p < 2) p = 2;
    return p;
  endfunction

  task automatic apply(logic [8:0] c, logic [31:0] t);
    @(negedge clk);
    code = c;
    arb_therm = t;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic expect_all(logic [8:0] c, logic [31:0] t);
    int p, tap, nx, ones;
    logic [3:0] eo, ee;
    logic [15:0] eb;
    p = ref_period(t);
    tap = int'(c[8:4]) % p;
    nx = (tap == 31) ? 0 : tap + 1;
    eo = 4'(((tap % 2 == 1) ? tap : nx) / 2);
    ee = 4'(((tap % 2 == 0) ? tap : nx) / 2);
    ones = (nx % 2 == 1) ? int'(c[3:0]) : 16 - int'(c[3:0]);
    eb = '0;
    for (int k = 0; k < 16; k++) if (k < ones) eb[k] = 1'b1;
    check("R4/R5 odd_sel", 32'(odd_sel), 32'(eo));
    check("R4/R5 even_sel", 32'(even_sel), 32'(ee));
    check("R6 blend_therm", 32'(blend_therm), 32'(eb));
    check("R3/R7 stage_mode", stage_mode, 32'h1 << (p - 1));
  endtask

  task automatic t_reset;
    check("R1 odd_sel", 32'(odd_sel), 0);
    check("R1 even_sel", 32'(even_sel), 0);
    check("R1 blend_therm", 32'(blend_therm), 0);
    check("R1 stage_mode", stage_mode, 32'h8000_0000);
  endtask

  task automatic t_full_sweep;
    for (int c = 0; c < 512; c += 7) begin
      apply(9'(c), 32'hFFFF_FFFF);
      expect_all(9'(c), 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_modulo_r4;
    for (int p = 2; p <= 31; p += 3) begin
      logic [31:0] t;
      t = (32'h1 << p) - 1;
      for (int co = 0; co < 32; co += 5) begin
        apply({5'(co), 4'(co % 16)}, t);
        expect_all({5'(co), 4'(co % 16)}, t);
      end
    end
  endtask

  task automatic t_bubble_r3;
    logic [31:0] t;
    t = 32'h000F_FFDF;
    apply(9'h1F3, t);
    check("R3 hole bubble", stage_mode, 32'h1 << 19);
    expect_all(9'h1F3, t);
    t = 32'h0040_FFFF;
    apply(9'h1A5, t);
    check("R3 stray bubble", stage_mode, 32'h1 << 15);
    expect_all(9'h1A5, t);
    t = 32'h0000_0000;
    apply(9'h0F8, t);
    check("R3 clamp low", stage_mode, 32'h2);
    expect_all(9'h0F8, t);
    t = 32'h0000_0001;
    apply(9'h037, t);
    expect_all(9'h037, t);
  endtask

  task automatic t_wrap_r5;
    apply(9'h1F9, 32'hFFFF_FFFF);
    check("R5 wrap odd_sel", 32'(odd_sel), 15);
    check("R5 wrap even_sel", 32'(even_sel), 0);
    check("R6 wrap blend", 32'(blend_therm), 32'h007F);
  endtask

  task automatic t_hold_r2;
    logic [3:0] o, e;
    logic [15:0] b;
    logic [31:0] s;
    apply(9'h0A6, 32'h0000_FFFF);
    o = odd_sel; e = even_sel; b = blend_therm; s = stage_mode;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      code = 9'(i * 83 + 5);
      arb_therm = 32'h1 << i;
    end
    @(negedge clk);
    check("R2 hold odd_sel", 32'(odd_sel), 32'(o));
    check("R2 hold even_sel", 32'(even_sel), 32'(e));
    check("R2 hold blend", 32'(blend_therm), 32'(b));
    check("R2 hold stage", stage_mode, s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_full_sweep();
    t_modulo_r4();
    t_bubble_r3();
    t_wrap_r5();
    t_hold_r2();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule